// File: doc/BRIEF.md
# Pixel Column Hit Pointer Store

This block holds the digital state of one readout column of a pixel array: 256 rows by a left and a right physical column, 512 cells in all. Each cell owns a hit latch and a copy of the 2-bit buffer pointer that the column periphery broadcasts. When a cell's hit input pulses, the cell latches the hit, keeps the pointer value of that cycle, and the column raises a hit indication toward the periphery.

The periphery later presents a read pointer together with a discard flag. The block matches the stored pointer of every latched cell against it. It then reports the matching cells one per clock as a 9-bit address, lowest address first, and clears each cell as it is reported. When no match remains it raises a done pulse. A rejected event runs the same sequence with the discard flag set on every report, so every latched cell is cleared in the end. Cells are grouped four to a cluster: the cluster supplies the upper 7 address bits and each cell adds its own 2 low bits.

Top module: `pcol_hit_store`

## Requirements
- R1: After reset no cell is latched and hit_o, addr_valid_o, done_o and busy_o are low.
- R2: A hit pulse on a cell that is not latched latches it with the wr_ptr_i value of that cycle, and hit_o is high in the following cycle.
- R3: A hit pulse on an already latched cell has no effect: its stored pointer is kept and it does not raise hit_o.
- R4: A read reports every latched cell whose stored pointer equals rd_ptr_i, as address = row*2 + side, where side bit 0 is 0 for the left column and 1 for the right.
- R5: Reports come one per cycle in ascending address order; the first one is on addr_o in the second cycle after rd_req_i is sampled.
- R6: A reported cell is cleared and is not reported by a later read.
- R7: done_o pulses for one cycle in the cycle after the last report, or in the second cycle after rd_req_i when nothing matches, with addr_valid_o low.
- R8: discard_o equals the rd_discard_i value sampled with rd_req_i on every report of that read.
- R9: rd_req_i while a read is in progress (busy_o high) is ignored.
- R10: A hit pulse on a cell in the cycle it is being cleared latches it again with the new pointer.
- R11: Latched cells whose pointer does not match the read pointer keep their state through the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 512 | Per-cell hit pulses, bit index = row*2 + side |
| wr_ptr_i | input | 2 | Buffer pointer broadcast to all cells |
| rd_req_i | input | 1 | Start a read |
| rd_ptr_i | input | 2 | Pointer to match on a read |
| rd_discard_i | input | 1 | Mark this read's reports for discard |
| hit_o | output | 1 | A new hit was latched in the previous cycle |
| addr_o | output | 9 | Reported cell address |
| addr_valid_o | output | 1 | addr_o holds a report |
| discard_o | output | 1 | Current report is to be discarded |
| done_o | output | 1 | Read finished, no match left |
| busy_o | output | 1 | Read in progress |

## Verification
hit_o is due one cycle after the hit pulse, the first report two cycles after the read request, each further report one cycle later and done_o one cycle after the last report. The bench drives inputs on the falling edge and samples outputs on the falling edge at exactly those offsets, walking a reference model's ascending list of matching cells one sample per cycle. Ignored requests and ignored hits are checked by later reads that reveal the state they could have changed.

// File: rtl/pcol_pkg.sv
package pcol_pkg;
  localparam int ROW_W_DEF = 8;
  localparam int PTR_W_DEF = 2;
  localparam int LOW_W_DEF = 2;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_SCAN = 1'b1
  } rd_state_e;
endpackage

// File: rtl/pcol_cell.sv
module pcol_cell #(
  parameter int PTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  logic             clr_i,
  output logic             match_o,
  output logic             new_o
);
  logic             lat_q;
  logic [PTR_W-1:0] ptr_q;

  assign new_o   = hit_i & (~lat_q | clr_i);
  assign match_o = lat_q & (ptr_q == rd_ptr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      ptr_q <= '0;
    end else if (clr_i) begin
      lat_q <= hit_i;
      if (hit_i) ptr_q <= wr_ptr_i;
    end else if (hit_i && !lat_q) begin
      lat_q <= 1'b1;
      ptr_q <= wr_ptr_i;
    end
  end

  a_r3_hold_when_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !clr_i) |=> (lat_q && $stable(ptr_q)));

  a_r10_rehit_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i) |=> (lat_q && ptr_q == $past(wr_ptr_i)));
endmodule

// File: rtl/pcol_cluster.sv
module pcol_cluster #(
  parameter int PTR_W  = 2,
  parameter int LOW_W  = 2,
  parameter int ADDR_W = 9,
  parameter int CL_ID  = 0,
  localparam int CL_SZ = 1 << LOW_W,
  localparam int PFX_W = ADDR_W - LOW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CL_SZ-1:0]  hit_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic              clr_en_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  output logic [CL_SZ-1:0]  match_o,
  output logic [CL_SZ-1:0]  new_o
);
  // shared upper address bits decoded once per cluster
  logic pfx_hit;
  assign pfx_hit = clr_en_i && (clr_addr_i[ADDR_W-1:LOW_W] == PFX_W'(CL_ID));

  for (genvar k = 0; k < CL_SZ; k++) begin : g_cell
    logic clr;
    assign clr = pfx_hit && (clr_addr_i[LOW_W-1:0] == LOW_W'(k));
    pcol_cell #(.PTR_W(PTR_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit_i[k]),
      .wr_ptr_i (wr_ptr_i),
      .rd_ptr_i (rd_ptr_i),
      .clr_i    (clr),
      .match_o  (match_o[k]),
      .new_o    (new_o[k])
    );
  end
endmodule

// File: rtl/pcol_prio_enc.sv
module pcol_prio_enc #(
  parameter int N     = 512,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end

  a_r5_pick_is_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> req_i[idx_o]);

  a_r7_none_means_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> (req_i == '0));
endmodule

// File: rtl/pcol_hit_store.sv
module pcol_hit_store
  import pcol_pkg::*;
#(
  parameter int ROW_W = ROW_W_DEF,
  parameter int PTR_W = PTR_W_DEF,
  parameter int LOW_W = LOW_W_DEF,
  localparam int ADDR_W = ROW_W + 1,
  localparam int NCELL  = 1 << ADDR_W,
  localparam int CL_SZ  = 1 << LOW_W,
  localparam int NCL    = NCELL / CL_SZ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCELL-1:0]  hit_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic              rd_req_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic              rd_discard_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic              discard_o,
  output logic              done_o,
  output logic              busy_o
);
  rd_state_e         state_q;
  logic [PTR_W-1:0]  rd_ptr_q;
  logic              disc_q;
  logic [NCELL-1:0]  match;
  logic [NCELL-1:0]  new_hit;
  logic [ADDR_W-1:0] pick;
  logic              found;
  logic              fire;

  assign fire   = (state_q == RD_SCAN) && found;
  assign busy_o = (state_q == RD_SCAN);

  for (genvar g = 0; g < NCL; g++) begin : g_cl
    pcol_cluster #(
      .PTR_W (PTR_W),
      .LOW_W (LOW_W),
      .ADDR_W(ADDR_W),
      .CL_ID (g)
    ) u_cl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (hit_i[g*CL_SZ +: CL_SZ]),
      .wr_ptr_i   (wr_ptr_i),
      .rd_ptr_i   (rd_ptr_q),
      .clr_en_i   (fire),
      .clr_addr_i (pick),
      .match_o    (match[g*CL_SZ +: CL_SZ]),
      .new_o      (new_hit[g*CL_SZ +: CL_SZ])
    );
  end

  pcol_prio_enc #(.N(NCELL), .IDX_W(ADDR_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (match),
    .idx_o   (pick),
    .found_o (found)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= |new_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RD_IDLE;
      rd_ptr_q     <= '0;
      disc_q       <= 1'b0;
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
      discard_o    <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      addr_valid_o <= 1'b0;
      done_o       <= 1'b0;
      case (state_q)
        RD_IDLE: if (rd_req_i) begin
          state_q  <= RD_SCAN;
          rd_ptr_q <= rd_ptr_i;
          disc_q   <= rd_discard_i;
        end
        RD_SCAN: if (found) begin
          addr_o       <= pick;
          addr_valid_o <= 1'b1;
          discard_o    <= disc_q;
        end else begin
          done_o  <= 1'b1;
          state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  a_r7_done_not_with_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && addr_valid_o));

  a_r7_done_ends_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_ptr_held_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_req_i) |=> $stable(rd_ptr_q));

  a_r5_report_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> $past(busy_o));
endmodule

// File: tb/pcol_hit_store_tb.sv
`timescale 1ns/1ps
module pcol_hit_store_tb;
  localparam int NC = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] hit_i = '0;
  logic [1:0] wr_ptr_i = '0;
  logic rd_req_i = 1'b0;
  logic [1:0] rd_ptr_i = '0;
  logic rd_discard_i = 1'b0;
  logic hit_o, addr_valid_o, discard_o, done_o, busy_o;
  logic [8:0] addr_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  bit m_lat [NC];
  logic [1:0] m_ptr [NC];

  always #2.5 clk = ~clk;

  pcol_hit_store u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit_i), .wr_ptr_i(wr_ptr_i),
    .rd_req_i(rd_req_i), .rd_ptr_i(rd_ptr_i), .rd_discard_i(rd_discard_i),
    .hit_o(hit_o), .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .discard_o(discard_o), .done_o(done_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hit_cells(input int cells[$], input logic [1:0] p, input string req);
    bit any = 0;
    @(negedge clk);
    foreach (cells[i]) begin
      if (!m_lat[cells[i]]) begin
        m_lat[cells[i]] = 1;
        m_ptr[cells[i]] = p;
        any = 1;
      end
      hit_i[cells[i]] = 1'b1;
    end
    wr_ptr_i = p;
    @(negedge clk);
    hit_i = '0;
    chk(hit_o == any, req, "hit_o", int'(hit_o), int'(any));
  endtask

  // bz: second request during busy; rh: re-hit first reported cell on its clear cycle
  task automatic rd(input logic [1:0] p, input bit disc, input bit bz, input logic [1:0] bp,
                    input bit rh, input int rc, input logic [1:0] rp, input string req);
    int exp_q[$];
    for (int c = 0; c < NC; c++)
      if (m_lat[c] && m_ptr[c] == p) begin
        exp_q.push_back(c);
        m_lat[c] = 0;
      end
    @(negedge clk);
    rd_req_i = 1'b1; rd_ptr_i = p; rd_discard_i = disc;
    @(negedge clk);
    if (bz) begin rd_ptr_i = bp; rd_discard_i = ~disc; end
    else rd_req_i = 1'b0;
    if (rh) begin hit_i[rc] = 1'b1; wr_ptr_i = rp; end
    chk(busy_o == 1'b1, "R9", "busy_o", int'(busy_o), 1);
    foreach (exp_q[i]) begin
      @(negedge clk);
      rd_req_i = 1'b0; hit_i = '0;
      chk(addr_valid_o == 1'b1, req, "addr_valid_o", int'(addr_valid_o), 1);
      chk(addr_o == 9'(exp_q[i]), req, "addr_o", int'(addr_o), exp_q[i]);
      chk(discard_o == disc, "R8", "discard_o", int'(discard_o), int'(disc));
    end
    @(negedge clk);
    rd_req_i = 1'b0; hit_i = '0;
    chk(done_o == 1'b1 && addr_valid_o == 1'b0, "R7", "done_o", int'(done_o), 1);
    if (rh) begin m_lat[rc] = 1; m_ptr[rc] = rp; end
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R7", "busy_o after done", int'(busy_o), 0);
  endtask

  task automatic t_reset();
    chk(hit_o == 0, "R1", "hit_o", int'(hit_o), 0);
    chk(addr_valid_o == 0 && done_o == 0, "R1", "valid/done", int'(addr_valid_o), 0);
    chk(busy_o == 0, "R1", "busy_o", int'(busy_o), 0);
    for (int p = 0; p < 4; p++) rd(2'(p), 0, 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_single();
    hit_cells('{5}, 2'd2, "R2");
    hit_cells('{8}, 2'd0, "R2");
    rd(2'd1, 0, 0, 0, 0, 0, 0, "R11");
    rd(2'd2, 0, 0, 0, 0, 0, 0, "R4");
    rd(2'd0, 0, 0, 0, 0, 0, 0, "R11");
  endtask

  task automatic t_ignore();
    hit_cells('{10}, 2'd1, "R2");
    hit_cells('{10}, 2'd3, "R3");
    rd(2'd3, 0, 0, 0, 0, 0, 0, "R3");
    rd(2'd1, 0, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_order();
    hit_cells('{300, 7, 6, 511, 0, 1}, 2'd0, "R5");
    rd(2'd0, 1, 0, 0, 0, 0, 0, "R5");
    rd(2'd0, 0, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_busy();
    hit_cells('{40, 41, 200}, 2'd2, "R2");
    hit_cells('{90}, 2'd3, "R2");
    rd(2'd2, 0, 1, 2'd3, 0, 0, 0, "R9");
    rd(2'd3, 1, 0, 0, 0, 0, 0, "R9");
  endtask

  task automatic t_rehit();
    hit_cells('{20}, 2'd1, "R2");
    rd(2'd1, 0, 0, 0, 1, 20, 2'd2, "R10");
    rd(2'd1, 0, 0, 0, 0, 0, 0, "R10");
    rd(2'd2, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic t_random();
    for (int r = 0; r < 30; r++) begin
      int cs[$];
      int n = 1 + int'($urandom_range(2));
      for (int j = 0; j < n; j++) cs.push_back(int'($urandom_range(NC - 1)));
      hit_cells(cs, 2'($urandom_range(3)), "R2");
    end
    for (int p = 0; p < 4; p++) rd(2'(p), p[0], 0, 0, 0, 0, 0, "R4");
    for (int p = 0; p < 4; p++) rd(2'(p), 0, 0, 0, 0, 0, 0, "R6");
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin m_lat[c] = 0; m_ptr[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_ignore();
    t_order();
    t_busy();
    t_rehit();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule